// File: doc/BRIEF.md
# Bitwise Arbitrating Byte Transmitter

This block shifts message bytes, most significant bit first, onto a wired-AND serial bus where logic 0 dominates and logic 1 is recessive. A slot strobe marks the end of each bit time. On each strobe the block compares the level it drove with the level read back from the bus. On a match it moves to the next bit. On a mismatch it gives up the bus. A host starts a message with a one-cycle start request and then supplies bytes through a valid/ready handshake. A one-byte holding register lets the host hand over the next byte while the current one is on the bus.

When the lost bit is the last bit of a byte, the block does not go quiet at once. It drives up to two more recessive bits and arbitrates each one. If the bus overrides the first of them, the second is not driven. After these bits the block releases the bus and abandons the message. Symbol pulse timing, frame delimiters, CRC and receive-side checks sit outside this block.

Top module: `arb_tx`

## Requirements
- R1: After reset the block is idle. `tx_bit_o` is 1, and `active_o`, `byte_ready_o`, `arb_lost_o` and `byte_done_o` are 0.
- R2: A start request while idle raises `active_o` on the next cycle. `byte_ready_o` then stays 1 until the first byte is accepted.
- R3: While sending, `tx_bit_o` shows the current byte MSB first. It advances one bit on each slot strobe whose readback equals the driven bit.
- R4: On bits 1 to 7 of a byte, a strobe with driven 1 and readback 0 gives a one-cycle `arb_lost_o` pulse on the next cycle. In that same cycle `active_o` falls and `tx_bit_o` returns to 1.
- R5: A strobe with driven 0 and readback 1 stops the message on the next cycle without an `arb_lost_o` pulse.
- R6: A loss on bit 8 gives one `arb_lost_o` pulse. The block then stays active and drives 1 for up to two further slots.
- R7: If the first appended 1 reads back as 0, the block goes idle after that slot. It drives no second appended bit and gives no further `arb_lost_o` pulse.
- R8: After the second appended slot the block goes idle whatever the readback, with no `arb_lost_o` pulse.
- R9: A strobe on bit 8 with matching readback gives a one-cycle `byte_done_o` pulse. If a next byte is available, its first bit is driven in the same cycle as the pulse.
- R10: If no next byte is held or offered when a byte completes, the message ends and `active_o` falls together with the `byte_done_o` pulse.
- R11: While sending, `byte_ready_o` is 1 exactly when the one-entry holding register is empty. The holding register is emptied when a message is abandoned.
- R12: While idle, slot strobes have no effect. While active, start requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a new message |
| byte_valid_i | input | 1 | Host offers a byte |
| byte_data_i | input | 8 | Offered byte |
| byte_ready_o | output | 1 | Block can accept a byte |
| slot_i | input | 1 | End-of-bit-slot strobe |
| bus_rx_i | input | 1 | Level read back from the bus |
| tx_bit_o | output | 1 | Level driven onto the bus (1 = recessive) |
| active_o | output | 1 | Transmitter owns or is contending for the bus |
| arb_lost_o | output | 1 | One-cycle pulse on lost arbitration |
| byte_done_o | output | 1 | One-cycle pulse on a completed byte |

## Verification
The assertions assume that the readback sampled on a slot strobe follows the level the block itself drives that cycle. They also assume that a strobe lasts a single cycle. The stimulus meets both conditions by building the readback each cycle as the wired AND of the block's expected driven bit with a random other-node bit. A rare injected 1 over a driven 0 stands in for a bus fault. Strobes, start requests and byte offers are drawn at random. Directed sequences then force losses on bit 3 and on bit 8, both outcomes of the appended bits, a fault, and strobes while idle.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SEND  = 3'd2,
    ST_TAIL1 = 3'd3,
    ST_TAIL2 = 3'd4
  } tx_state_t;
endpackage

// File: rtl/arb_tx_hold.sv
module arb_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         clr,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_d;
  logic [W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (clr || rd_en) full_d = 1'b0;
    else if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      if (wr_en) data <= data_d;
    end
  end
endmodule

// File: rtl/arb_tx_shift.sv
module arb_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         adv,
  output logic         msb,
  output logic         last
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_data;
      cnt_d = CW'(1);
    end else if (adv) begin
      sh_d  = {sh_q[W-2:0], 1'b1};
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load || adv) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb  = sh_q[W-1];
  assign last = (cnt_q == CW'(W));
endmodule

// File: rtl/arb_tx_ctrl.sv
module arb_tx_ctrl
  import arb_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic byte_valid_i,
  input  logic slot_i,
  input  logic bus_rx_i,
  input  logic shift_msb_i,
  input  logic shift_last_i,
  input  logic hold_full_i,
  output logic byte_ready_o,
  output logic tx_bit_o,
  output logic active_o,
  output logic arb_lost_o,
  output logic byte_done_o,
  output logic load_o,
  output logic load_from_hold_o,
  output logic shift_o,
  output logic hold_wr_o,
  output logic hold_clr_o
);
  tx_state_t st_q, st_d;
  logic      lost_d, done_d;
  logic      match;

  assign tx_bit_o     = (st_q == ST_SEND) ? shift_msb_i : 1'b1;
  assign active_o     = (st_q != ST_IDLE);
  assign byte_ready_o = (st_q == ST_LOAD) || ((st_q == ST_SEND) && !hold_full_i);
  assign match        = (tx_bit_o == bus_rx_i);

  always_comb begin
    st_d             = st_q;
    lost_d           = 1'b0;
    done_d           = 1'b0;
    load_o           = 1'b0;
    load_from_hold_o = 1'b0;
    shift_o          = 1'b0;
    hold_wr_o        = 1'b0;
    hold_clr_o       = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_LOAD;
      ST_LOAD: if (byte_valid_i) begin
        load_o = 1'b1;
        st_d   = ST_SEND;
      end
      ST_SEND: begin
        hold_wr_o = byte_valid_i && !hold_full_i;
        if (slot_i) begin
          if (match) begin
            if (shift_last_i) begin
              done_d = 1'b1;
              if (hold_full_i) begin
                load_o           = 1'b1;
                load_from_hold_o = 1'b1;
              end else if (byte_valid_i) begin
                load_o    = 1'b1;
                hold_wr_o = 1'b0;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              shift_o = 1'b1;
            end
          end else begin
            hold_clr_o = 1'b1;
            hold_wr_o  = 1'b0;
            if (tx_bit_o) begin
              lost_d = 1'b1;
              st_d   = shift_last_i ? ST_TAIL1 : ST_IDLE;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end
      ST_TAIL1: if (slot_i) st_d = bus_rx_i ? ST_TAIL2 : ST_IDLE;
      ST_TAIL2: if (slot_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      arb_lost_o  <= 1'b0;
      byte_done_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      arb_lost_o  <= lost_d;
      byte_done_o <= done_d;
    end
  end
endmodule

// File: rtl/arb_tx.sv
module arb_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  input  logic              slot_i,
  input  logic              bus_rx_i,
  output logic              tx_bit_o,
  output logic              active_o,
  output logic              arb_lost_o,
  output logic              byte_done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              load, load_from_hold, adv, hold_wr, hold_clr;
  logic              msb, last, hold_full;
  logic [BYTE_W-1:0] hold_data, load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign load_data = load_from_hold ? hold_data : byte_data_i;

  arb_tx_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n_s),
    .start_i          (start_i),
    .byte_valid_i     (byte_valid_i),
    .slot_i           (slot_i),
    .bus_rx_i         (bus_rx_i),
    .shift_msb_i      (msb),
    .shift_last_i     (last),
    .hold_full_i      (hold_full),
    .byte_ready_o     (byte_ready_o),
    .tx_bit_o         (tx_bit_o),
    .active_o         (active_o),
    .arb_lost_o       (arb_lost_o),
    .byte_done_o      (byte_done_o),
    .load_o           (load),
    .load_from_hold_o (load_from_hold),
    .shift_o          (adv),
    .hold_wr_o        (hold_wr),
    .hold_clr_o       (hold_clr)
  );

  arb_tx_shift #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (load),
    .load_data (load_data),
    .adv       (adv),
    .msb       (msb),
    .last      (last)
  );

  arb_tx_hold #(.W(BYTE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (hold_wr),
    .wr_data (byte_data_i),
    .rd_en   (load_from_hold),
    .clr     (hold_clr),
    .full    (hold_full),
    .data    (hold_data)
  );
endmodule

// File: rtl/arb_tx_chk.sv
module arb_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic slot_i,
  input logic bus_rx_i,
  input logic tx_bit_o,
  input logic active_o,
  input logic arb_lost_o,
  input logic byte_done_o
);
  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> tx_bit_o); // R4
  AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |=> !arb_lost_o); // R6
  AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> $past(slot_i && tx_bit_o && !bus_rx_i)); // R4
  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && active_o && !tx_bit_o && bus_rx_i) |=> (!active_o && !arb_lost_o)); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> $past(slot_i && tx_bit_o == bus_rx_i)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i) |=> !active_o); // R12
endmodule

bind arb_tx arb_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .slot_i      (slot_i),
  .bus_rx_i    (bus_rx_i),
  .tx_bit_o    (tx_bit_o),
  .active_o    (active_o),
  .arb_lost_o  (arb_lost_o),
  .byte_done_o (byte_done_o)
);

// File: tb/arb_tx_tb.sv
module arb_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, byte_valid_i, slot_i, bus_rx_i;
  logic [7:0] byte_data_i;
  logic       byte_ready_o, tx_bit_o, active_o, arb_lost_o, byte_done_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done_flag = 1'b0;

  // bench model: 0 idle, 1 load, 2 send, 3 tail1, 4 tail2
  int       m_st = 0;
  int       m_cnt = 0;
  logic [7:0] m_sh = 8'hFF, m_hb = 8'h00;
  bit       m_hf = 0, m_lost = 0, m_done = 0;
  string    ctx = "R1";

  arb_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o), .slot_i(slot_i),
    .bus_rx_i(bus_rx_i), .tx_bit_o(tx_bit_o), .active_o(active_o),
    .arb_lost_o(arb_lost_o), .byte_done_o(byte_done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_tx();
    return (m_st == 2) ? m_sh[7] : 1'b1;
  endfunction
  function automatic logic exp_ready();
    return (m_st == 1) || (m_st == 2 && !m_hf);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(tx_bit_o,     exp_tx(),    ctx, "tx_bit_o");
    check(active_o,     m_st != 0,   ctx, "active_o");
    check(byte_ready_o, exp_ready(), ctx, "byte_ready_o");
    check(arb_lost_o,   m_lost,      ctx, "arb_lost_o");
    check(byte_done_o,  m_done,      ctx, "byte_done_o");
  endtask

  // one clock: compare, drive, advance model
  task automatic step(input bit st, input bit vld, input logic [7:0] d,
                      input bit sl, input bit oth, input bit flt);
    logic tx, rx;
    bit   acc, used;
    @(negedge clk);
    compare_all();
    tx = exp_tx();
    rx = flt ? 1'b1 : (tx & oth);
    start_i = st; byte_valid_i = vld; byte_data_i = d; slot_i = sl; bus_rx_i = rx;
    m_lost = 0; m_done = 0; used = 0;
    case (m_st)
      0: begin
        if (st) begin m_st = 1; ctx = "R2"; end
        else if (sl) ctx = "R12";
      end
      1: if (vld) begin m_sh = d; m_cnt = 1; m_st = 2; ctx = "R3"; end
      2: begin
        acc = vld && !m_hf;
        if (st) ctx = "R12";
        if (sl) begin
          if (rx == tx) begin
            if (m_cnt == 8) begin
              m_done = 1;
              if (m_hf) begin m_sh = m_hb; m_hf = 0; m_cnt = 1; ctx = "R9"; end
              else if (vld) begin m_sh = d; m_cnt = 1; used = 1; ctx = "R9"; end
              else begin m_st = 0; ctx = "R10"; end
            end else begin
              m_sh = {m_sh[6:0], 1'b1}; m_cnt++; ctx = "R3";
            end
          end else if (tx) begin
            m_lost = 1; m_hf = 0;
            if (m_cnt == 8) begin m_st = 3; ctx = "R6"; end
            else begin m_st = 0; ctx = "R4"; end
          end else begin
            m_st = 0; m_hf = 0; ctx = "R5";
          end
        end
        if (m_st == 2 && acc && !used) begin m_hb = d; m_hf = 1; ctx = "R11"; end
      end
      3: if (sl) begin
        if (rx) begin m_st = 4; ctx = "R8"; end
        else begin m_st = 0; ctx = "R7"; end
      end
      4: if (sl) begin m_st = 0; ctx = "R8"; end
      default: m_st = 0;
    endcase
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 1, 0);
  endtask

  // start a message with byte d, then push k matching bits
  task automatic begin_msg(input logic [7:0] d, input int k);
    step(1, 0, 8'h00, 0, 1, 0);
    step(0, 1, d, 0, 1, 0);
    for (int i = 0; i < k; i++) step(0, 0, 8'h00, 1, 1, 0);
  endtask

  initial begin
    start_i = 0; byte_valid_i = 0; byte_data_i = 0; slot_i = 0; bus_rx_i = 1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    ctx = "R1";
    idle_cycles(2); // R1 reset state compared here

    // R12: strobes and a dominant bus while idle do nothing
    for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 1, 0, 0);
    idle_cycles(1);

    // R4: loss on bit 3 of 8'hFF
    begin_msg(8'hFF, 2);
    step(0, 0, 8'h00, 1, 0, 0);
    idle_cycles(2);

    // R6 and R7: loss on bit 8, first appended bit overridden
    begin_msg(8'hFF, 7);
    step(0, 0, 8'h00, 1, 0, 0);
    step(0, 0, 8'h00, 0, 1, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    idle_cycles(2);

    // R8: loss on bit 8, both appended bits sent, second overridden
    begin_msg(8'hFE, 7);
    step(0, 0, 8'h00, 1, 1, 0); // bit 8 of FE is 0: matches, ends msg (R10)
    begin_msg(8'h81, 7);
    step(0, 0, 8'h00, 1, 0, 0);
    step(0, 0, 8'h00, 1, 1, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    idle_cycles(2);

    // R5: fault, drove 0 read 1
    begin_msg(8'h3C, 0);
    step(0, 0, 8'h00, 1, 1, 1);
    idle_cycles(2);

    // R9 and R11: two bytes back to back through the holding register
    begin_msg(8'hA5, 0);
    step(0, 1, 8'h5A, 0, 1, 0);
    step(1, 1, 8'h77, 0, 1, 0);
    for (int i = 0; i < 16; i++) step(0, 0, 8'h00, 1, 1, 0);
    idle_cycles(2);

    // constrained random traffic
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 30000; i++) begin
      step(($urandom % 8) == 0, ($urandom % 3) == 0, 8'($urandom),
           ($urandom % 3) == 0, ($urandom % 12) != 0, ($urandom % 64) == 0);
    end
    idle_cycles(1);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_flag) begin
      done_flag = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles at most", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule